// File: doc/BRIEF.md
# Serial Management Target with Interrupt Register

This block is the device side of a two-wire serial management link. It runs only on the management clock. On each rising clock edge it takes one bit from the data line and parses the frame: at least 32 ones, a start pair, an operation code, a 5-bit device address, a 5-bit register address, a 2-bit turnaround and 16 data bits. Five strap inputs set the address that the block answers to. It ignores frames for any other address.

A write to one of its registers stores the data. On a read, the block takes control of the data line during the turnaround and sends the register contents, most significant bit first, with an output-enable that drives an external tri-state buffer. The register set has these parts:
- a writable control word at register 0;
- read-only words at registers 1 to 6;
- an interrupt register at 0x1B, with enables in the upper byte and event flags in the lower byte;
- a configuration word at 0x1F, whose bit 9 sets the polarity of the interrupt pin.

Event flags latch on one-cycle strobes. A read of 0x1B clears them.

Top module: `mdio_target`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones have been sampled; a frame preceded by fewer ones has no effect.
- R2: After the preamble, the start field must be 0 then 1 and the opcode must be 10 (read) or 01 (write); any other start or opcode abandons the frame with the output released and nothing written.
- R3: Frames whose 5-bit address field differs from `phy_addr` never enable the output and never change a register.
- R4: On a matching read, `mdio_oe` stays low during the first turnaround bit, the block drives 0 for the second, and then drives the 16 data bits MSB first, each valid at the rising edge on which it is sampled.
- R5: Register 0 (reset value 0x1000) and register 0x1F (reset value 0x0000) store all 16 bits of a write and return them on a read.
- R6: Registers 1 to 6 return fixed values (reg 2 = 0x2000, reg 5 = 0x05E1) and ignore writes.
- R7: A read of any register address outside 0 to 6, 0x1B and 0x1F returns 0x0000.
- R8: In register 0x1B, a write sets the enables in bits 15:8 and leaves flag bits 7:0 unchanged; a high bit on `irq_event[i]` sets flag bit i on the next edge, whatever the enable.
- R9: A read of register 0x1B returns the flags as they were before the read and clears them; an event in the same cycle as the clear still sets its flag.
- R10: The interrupt is active while any flag bit i and enable bit 8+i are both set; `irq_pin` equals the active state when 0x1F bit 9 is 1 and its inverse when bit 9 is 0.
- R11: During reset `mdio_oe` is low and `irq_pin` is high (inactive, polarity bit 0).
- R12: The output enable is held for exactly 17 cycles per read (turnaround 0 plus 16 data bits) and is released at the rising edge that follows the last data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped device address |
| mdio_i | input | 1 | Sampled data line |
| mdio_o | output | 1 | Data driven back during a read |
| mdio_oe | output | 1 | Enable for the external tri-state driver |
| irq_event | input | 8 | One-cycle event strobes that set the interrupt flags |
| irq_pin | output | 1 | Interrupt output, polarity from register 0x1F bit 9 |

## Verification
The bench sends complete frames through a host model on a line pulled high. The stimulus covers:
- matched and mismatched device addresses, which separates address filtering from register access;
- a preamble one bit short and an illegal opcode, which shows that the parser rejects a frame early and does not just skip the write;
- reads of the writable, read-only, interrupt and unimplemented addresses, each expected to give a different value;
- event strobes with the enables on and off, and under both polarity settings, which separates flag latching from pin gating;
- two reads in a row of the interrupt register, which shows clear-on-read because the first returns the flags and the second returns zero.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;

    localparam int MDIO_DW = 16;
    localparam int MDIO_AW = 5;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } fsm_state_e;

    typedef struct packed {
        fsm_state_e           st;
        logic                 is_rd;
        logic                 op_hi;
        logic [MDIO_AW-1:0]   adr;
        logic                 hit;
        logic [MDIO_DW-1:0]   sh;
        logic                 drv;
        logic                 oe;
    } fsm_t;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_target_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MDIO_AW-1:0] phy_addr,
    input  logic               mdio_i,
    input  logic [MDIO_DW-1:0] rd_data,
    output logic               rd_stb,
    output logic               wr_stb,
    output logic [MDIO_AW-1:0] acc_addr,
    output logic [MDIO_DW-1:0] wr_data,
    output logic               mdio_o,
    output logic               mdio_oe
);

    localparam int CW_P  = $clog2(PRE_LEN + 1);
    localparam int CW_D  = $clog2(MDIO_DW);
    localparam int CNT_W = (CW_P > CW_D) ? CW_P : CW_D;
    localparam logic [CNT_W-1:0] PRE_FULL = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(MDIO_AW - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(MDIO_DW - 1);

    fsm_t             s_d, s_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [MDIO_AW-1:0] adr_in;

    assign adr_in  = {s_q.adr[MDIO_AW-2:0], mdio_i};
    assign wr_data = {s_q.sh[MDIO_DW-2:0], mdio_i};

    always_comb begin
        s_d      = s_q;
        cnt_d    = cnt_q;
        rd_stb   = 1'b0;
        wr_stb   = 1'b0;
        acc_addr = s_q.adr;
        case (s_q.st)
            ST_PRE: begin
                if (mdio_i) begin
                    if (cnt_q != PRE_FULL) cnt_d = cnt_q + 1'b1;
                end else if (cnt_q == PRE_FULL) begin
                    s_d.st = ST_START;
                    cnt_d  = '0;
                end else begin
                    cnt_d = '0;
                end
            end
            ST_START: begin
                s_d.st = mdio_i ? ST_OP : ST_PRE;
                cnt_d  = '0;
            end
            ST_OP: begin
                if (cnt_q == '0) begin
                    s_d.op_hi = mdio_i;
                    cnt_d     = 1;
                end else if (s_q.op_hi != mdio_i) begin
                    s_d.is_rd = s_q.op_hi;
                    s_d.st    = ST_PHY;
                    cnt_d     = '0;
                end else begin
                    s_d.st = ST_PRE;
                    cnt_d  = '0;
                end
            end
            ST_PHY: begin
                s_d.adr = adr_in;
                if (cnt_q == ADR_LAST) begin
                    s_d.hit = (adr_in == phy_addr);
                    s_d.st  = ST_REG;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_REG: begin
                acc_addr = adr_in;
                s_d.adr  = adr_in;
                if (cnt_q == ADR_LAST) begin
                    s_d.st = ST_TA;
                    cnt_d  = '0;
                    if (s_q.hit && s_q.is_rd) begin
                        rd_stb = 1'b1;
                        s_d.sh = rd_data;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_TA: begin
                if (cnt_q == '0) begin
                    if (s_q.hit && s_q.is_rd) begin
                        s_d.oe  = 1'b1;
                        s_d.drv = 1'b0;
                    end
                    cnt_d = 1;
                end else begin
                    if (s_q.oe) begin
                        s_d.drv = s_q.sh[MDIO_DW-1];
                        s_d.sh  = {s_q.sh[MDIO_DW-2:0], 1'b0};
                    end
                    s_d.st = ST_DATA;
                    cnt_d  = '0;
                end
            end
            ST_DATA: begin
                if (s_q.oe) begin
                    s_d.drv = s_q.sh[MDIO_DW-1];
                    s_d.sh  = {s_q.sh[MDIO_DW-2:0], 1'b0};
                end else begin
                    s_d.sh = wr_data;
                end
                if (cnt_q == DAT_LAST) begin
                    wr_stb  = s_q.hit && !s_q.is_rd;
                    s_d.oe  = 1'b0;
                    s_d.drv = 1'b0;
                    s_d.st  = ST_PRE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                s_d.st = ST_PRE;
                cnt_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q   <= '{st: ST_PRE, default: '0};
            cnt_q <= '0;
        end else begin
            s_q   <= s_d;
            cnt_q <= cnt_d;
        end
    end

    assign mdio_o  = s_q.drv;
    assign mdio_oe = s_q.oe;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_target_pkg::*;
#(
    parameter logic [MDIO_DW-1:0] CTRL_RST = 16'h1000,
    parameter int                 N_RO     = 6,
    parameter logic [N_RO*MDIO_DW-1:0] RO_VALS =
        {16'h0000, 16'h05E1, 16'h01E1, 16'h5C90, 16'h2000, 16'h7849}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [MDIO_AW-1:0] acc_addr,
    input  logic [MDIO_DW-1:0] wr_data,
    input  logic [MDIO_DW-1:0] irq_word,
    output logic [MDIO_DW-1:0] rd_data,
    output logic               irq_pol
);

    localparam logic [MDIO_AW-1:0] A_CTRL = 5'h00;
    localparam logic [MDIO_AW-1:0] A_IRQ  = 5'h1B;
    localparam logic [MDIO_AW-1:0] A_CFG  = 5'h1F;
    localparam int                 POL_BIT = 9;

    logic [MDIO_DW-1:0] ctrl_d, ctrl_q;
    logic [MDIO_DW-1:0] cfg_d,  cfg_q;

    always_comb begin
        ctrl_d  = ctrl_q;
        cfg_d   = cfg_q;
        rd_data = '0;
        if (wr_stb && acc_addr == A_CTRL) ctrl_d = wr_data;
        if (wr_stb && acc_addr == A_CFG)  cfg_d  = wr_data;
        if (acc_addr == A_CTRL)      rd_data = ctrl_q;
        else if (acc_addr == A_IRQ)  rd_data = irq_word;
        else if (acc_addr == A_CFG)  rd_data = cfg_q;
        for (int i = 1; i <= N_RO; i++) begin
            if (acc_addr == MDIO_AW'(i)) rd_data = RO_VALS[MDIO_DW*(i-1) +: MDIO_DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            cfg_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            cfg_q  <= cfg_d;
        end
    end

    assign irq_pol = cfg_q[POL_BIT];

endmodule

// File: rtl/mdio_irq_unit.sv
module mdio_irq_unit
    import mdio_target_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic               rd_stb,
    input  logic [MDIO_AW-1:0] acc_addr,
    input  logic [N_SRC-1:0]   en_wr,
    input  logic [N_SRC-1:0]   irq_event,
    input  logic               irq_pol,
    output logic [2*N_SRC-1:0] irq_word,
    output logic               irq_pin
);

    localparam logic [MDIO_AW-1:0] A_IRQ = 5'h1B;

    logic [N_SRC-1:0] en_d,  en_q;
    logic [N_SRC-1:0] flg_d, flg_q;
    logic             active;

    always_comb begin
        en_d  = en_q;
        flg_d = flg_q;
        if (wr_stb && acc_addr == A_IRQ) en_d = en_wr;
        if (rd_stb && acc_addr == A_IRQ) flg_d = '0;
        flg_d = flg_d | irq_event;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            flg_q <= '0;
        end else begin
            en_q  <= en_d;
            flg_q <= flg_d;
        end
    end

    assign active   = |(en_q & flg_q);
    assign irq_pin  = irq_pol ? active : !active;
    assign irq_word = {en_q, flg_q};

endmodule

// File: rtl/mdio_target.sv
module mdio_target
    import mdio_target_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int N_SRC   = 8
) (
    input  logic               mdc,
    input  logic               rst_n,
    input  logic [MDIO_AW-1:0] phy_addr,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic [N_SRC-1:0]   irq_event,
    output logic               irq_pin
);

    logic               rd_stb_w, wr_stb_w, irq_pol_w;
    logic [MDIO_AW-1:0] acc_addr_w;
    logic [MDIO_DW-1:0] wr_data_w, rd_data_w;
    logic [2*N_SRC-1:0] irq_word_w;

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk      (mdc),
        .rst_n    (rst_n),
        .phy_addr (phy_addr),
        .mdio_i   (mdio_i),
        .rd_data  (rd_data_w),
        .rd_stb   (rd_stb_w),
        .wr_stb   (wr_stb_w),
        .acc_addr (acc_addr_w),
        .wr_data  (wr_data_w),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mdio_reg_bank u_bank (
        .clk      (mdc),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb_w),
        .acc_addr (acc_addr_w),
        .wr_data  (wr_data_w),
        .irq_word (irq_word_w),
        .rd_data  (rd_data_w),
        .irq_pol  (irq_pol_w)
    );

    mdio_irq_unit #(.N_SRC(N_SRC)) u_irq (
        .clk       (mdc),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb_w),
        .rd_stb    (rd_stb_w),
        .acc_addr  (acc_addr_w),
        .en_wr     (wr_data_w[MDIO_DW-1 -: N_SRC]),
        .irq_event (irq_event),
        .irq_pol   (irq_pol_w),
        .irq_word  (irq_word_w),
        .irq_pin   (irq_pin)
    );

endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk #(
    parameter int N_SRC = 8
) (
    input logic               mdc,
    input logic               rst_n,
    input logic               mdio_o,
    input logic               mdio_oe,
    input logic               irq_pin,
    input logic [N_SRC-1:0]   irq_event,
    input logic [2*N_SRC-1:0] irq_word,
    input logic               pol,
    input logic               rd_stb,
    input logic [4:0]         acc_addr
);

    localparam int OE_SPAN = 16 + 1;

    logic [5:0] oe_run_q;

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n)       oe_run_q <= '0;
        else if (mdio_oe) oe_run_q <= oe_run_q + 1'b1;
        else              oe_run_q <= '0;
    end

    p_ta_zero_r4: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    p_oe_span_r12: assert property (@(posedge mdc) disable iff (!rst_n)
        (oe_run_q == 6'(OE_SPAN)) |-> !mdio_oe);

    p_flag_set_r8: assert property (@(posedge mdc) disable iff (!rst_n)
        (irq_event != '0) |=> ((irq_word[N_SRC-1:0] & $past(irq_event)) == $past(irq_event)));

    p_rd_clear_r9: assert property (@(posedge mdc) disable iff (!rst_n)
        (rd_stb && acc_addr == 5'h1B && irq_event == '0) |=> (irq_word[N_SRC-1:0] == '0));

    p_pin_level_r10: assert property (@(posedge mdc) disable iff (!rst_n)
        ((irq_pin == pol) == (|(irq_word[2*N_SRC-1:N_SRC] & irq_word[N_SRC-1:0]))));

endmodule

bind mdio_target mdio_target_chk #(.N_SRC(N_SRC)) u_chk (
    .mdc       (mdc),
    .rst_n     (rst_n),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .irq_pin   (irq_pin),
    .irq_event (irq_event),
    .irq_word  (irq_word_w),
    .pol       (irq_pol_w),
    .rd_stb    (rd_stb_w),
    .acc_addr  (acc_addr_w)
);

// File: tb/tb_mdio_target.sv
module tb_mdio_target;

    localparam logic [4:0] PHY = 5'h0D;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_drv = 1'b1;
    logic [7:0] ev = '0;
    logic       mdio_o, mdio_oe, irq_pin, line;
    int         checks = 0;
    int         fails = 0;

    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];
    string       req_q[$];
    event        rd_ev;

    always #10 mdc = ~mdc;

    assign line = mdio_oe ? mdio_o : host_drv;

    mdio_target dut (
        .mdc(mdc), .rst_n(rst_n), .phy_addr(PHY), .mdio_i(line),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq_event(ev), .irq_pin(irq_pin)
    );

    task automatic chk(input logic c, input string r, input logic [15:0] a, input logic [15:0] e);
        checks++;
        if (!c) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", r, a, e);
        end
    endtask

    task automatic tx_bit(input logic b);
        @(negedge mdc);
        host_drv = b;
    endtask

    task automatic header(input int pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
        for (int i = 0; i < pre; i++) tx_bit(1'b1);
        tx_bit(1'b0); tx_bit(1'b1);
        tx_bit(op[1]); tx_bit(op[0]);
        for (int i = 4; i >= 0; i--) tx_bit(pa[i]);
        for (int i = 4; i >= 0; i--) tx_bit(ra[i]);
    endtask

    task automatic wr_frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] d);
        header(pre, op, pa, ra);
        tx_bit(1'b1); tx_bit(1'b0);
        for (int i = 15; i >= 0; i--) tx_bit(d[i]);
        tx_bit(1'b1);
    endtask

    task automatic mdio_wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        wr_frame(32, 2'b01, pa, ra, d);
    endtask

    // driver: pushes the expected word, collects the returned word
    task automatic mdio_rd(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] exp, input string r);
        logic [15:0] w;
        logic        seen;
        header(32, 2'b10, pa, ra);
        @(negedge mdc);
        host_drv = 1'b1;
        chk(!mdio_oe, "R4 turnaround bit 1 released", 16'(mdio_oe), 16'h0);
        seen = 1'b0;
        @(negedge mdc);
        if (pa == PHY) chk(mdio_oe && !line, "R4 turnaround bit 2 driven 0", {14'h0, mdio_oe, line}, 16'h2);
        else seen = mdio_oe;
        w = '0;
        for (int i = 0; i < 16; i++) begin
            @(negedge mdc);
            seen = seen | mdio_oe;
            w = {w[14:0], line};
        end
        @(negedge mdc);
        chk(!mdio_oe, "R12 output released after read", 16'(mdio_oe), 16'h0);
        if (pa == PHY) begin
            exp_q.push_back(exp);
            act_q.push_back(w);
            req_q.push_back(r);
            -> rd_ev;
        end else begin
            chk(!seen, "R3 no drive for other address", 16'(seen), 16'h0);
        end
    endtask

    task automatic fire(input logic [7:0] m);
        @(negedge mdc);
        ev = m;
        @(negedge mdc);
        ev = '0;
    endtask

    // monitor: compares returned words against the scoreboard
    initial begin
        forever begin
            @(rd_ev);
            while (act_q.size() > 0) begin
                logic [15:0] a, e;
                string r;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(a == e, r, a, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge mdc);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge mdc);
        chk(!mdio_oe, "R11 oe low in reset", 16'(mdio_oe), 16'h0);
        chk(irq_pin, "R11 pin inactive high in reset", 16'(irq_pin), 16'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge mdc);

        mdio_rd(PHY, 5'h00, 16'h1000, "R5 reg0 reset value");
        mdio_wr(PHY, 5'h00, 16'hA5C3);
        mdio_rd(PHY, 5'h00, 16'hA5C3, "R5 reg0 write readback");

        mdio_rd(PHY, 5'h02, 16'h2000, "R6 reg2 fixed value");
        mdio_wr(PHY, 5'h02, 16'hFFFF);
        mdio_rd(PHY, 5'h02, 16'h2000, "R6 reg2 ignores write");
        mdio_rd(PHY, 5'h05, 16'h05E1, "R6 reg5 fixed value");

        mdio_rd(PHY, 5'h0A, 16'h0000, "R7 unimplemented reads zero");
        mdio_rd(PHY, 5'h1F, 16'h0000, "R5 reg1F reset value");

        mdio_rd(5'h0C, 5'h00, 16'h0000, "R3 other address read");
        mdio_wr(5'h0C, 5'h00, 16'h1111);
        mdio_rd(PHY, 5'h00, 16'hA5C3, "R3 other address write ignored");

        tx_bit(1'b0);
        wr_frame(31, 2'b01, PHY, 5'h00, 16'h2222);
        mdio_rd(PHY, 5'h00, 16'hA5C3, "R1 short preamble ignored");

        wr_frame(32, 2'b11, PHY, 5'h00, 16'h3333);
        mdio_rd(PHY, 5'h00, 16'hA5C3, "R2 bad opcode abandoned");

        mdio_wr(PHY, 5'h1B, 16'hFFFF);
        mdio_rd(PHY, 5'h1B, 16'hFF00, "R8 enables written flags untouched");

        fire(8'h05);
        chk(!irq_pin, "R10 active-low pin asserted", 16'(irq_pin), 16'h0);
        mdio_rd(PHY, 5'h1B, 16'hFF05, "R9 read returns flags");
        chk(irq_pin, "R10 pin released after clear", 16'(irq_pin), 16'h1);
        mdio_rd(PHY, 5'h1B, 16'hFF00, "R9 flags cleared by read");

        mdio_wr(PHY, 5'h1F, 16'h0200);
        chk(!irq_pin, "R10 active-high pin inactive", 16'(irq_pin), 16'h0);
        fire(8'h80);
        chk(irq_pin, "R10 active-high pin asserted", 16'(irq_pin), 16'h1);
        mdio_rd(PHY, 5'h1F, 16'h0200, "R5 reg1F write readback");

        mdio_wr(PHY, 5'h1B, 16'h00FF);
        chk(!irq_pin, "R10 disabled source gated off", 16'(irq_pin), 16'h0);
        mdio_rd(PHY, 5'h1B, 16'h0080, "R8 flag kept while disabled");
        fire(8'h02);
        mdio_rd(PHY, 5'h1B, 16'h0002, "R8 event sets flag without enable");
        chk(!irq_pin, "R10 no enable keeps pin inactive", 16'(irq_pin), 16'h0);

        repeat (2) @(negedge mdc);
        chk(act_q.size() == 0, "R4 scoreboard drained", 16'(act_q.size()), 16'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule